// File: doc/BRIEF.md
# Cascaded Search-Engine SRAM Read Sequencer

This block is the device-side control for one member of a cascade of up to eight search-engine devices sharing a host command bus, a 68-bit data bus and an external SRAM. The host issues a read as two consecutive command cycles, phase A then phase B. Every device watches the bus, and only the device whose strapped 5-bit identifier matches the ID field carried on the data bus in phase A takes the access.

The owning device then runs a fixed seven-cycle schedule. It leaves two turnaround cycles so the host can release the data bus, then drives the data bus for three cycles. It raises an acknowledge from high impedance to low, pulses it high while it places the 22-bit read address and the SRAM strobes on the SRAM side, and holds acknowledge low for one more cycle before releasing everything. Tri-state lines are modelled as a value plus an output enable. All outputs come straight from flops.

Top module: `srd_read_seq`

## Requirements
- R1: A read is taken when, in two consecutive cycles, `cmd_valid` is 1, `cmd[1:0]` equals the read opcode (parameter, default 2'b00) and `dq_in[20:19]` equals 2'b10; the device ID is checked in the first of the two cycles only.
- R2: The access is taken only if `dq_in[25:21]` in phase A equals `dev_id`; otherwise no output enable is ever raised.
- R3: A wrong opcode, `cmd_valid` low, or `dq_in[20:19]` other than 2'b10 in either phase starts no transaction and leaves all enables low.
- R4: The SRAM address is `{cmd[8:6], dq_in[18:0]}`, both taken in phase A; phase-B address bits are ignored.
- R5: In the two cycles after phase B (cycles 2 and 3), every output enable is low.
- R6: `dq_oe` is high in cycles 4, 5 and 6 only, and `dq_out` then carries the SRAM address zero-extended to 68 bits.
- R7: In cycle 5, `ack_oe` rises with `ack_out` at 0.
- R8: In cycle 6, `ack_out` is 1, `sram_addr` is driven with the address, and `ce_n`=0, `we_n`=1, `ale_n`=0 with `ctl_oe` and `sram_addr_oe` high.
- R9: In cycle 7, only `ack_oe` stays high with `ack_out` at 0; data bus, SRAM address and strobes are released.
- R10: After cycle 7 every enable is low, and a read whose phase A arrives in the very next cycle is taken.
- R11: Command cycles arriving between phase B and the end of cycle 7 are ignored.
- R12: Synchronous active-high `rst` returns the block to idle with every enable low, also in mid-transaction.
- R13: `drive_en` is `{ctl_oe, sram_addr_oe, ack_oe, dq_oe}`; while a line is not enabled it holds its idle value (`ack_out` 0, strobes 1, `sram_addr` 0, `dq_out` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_id | input | 5 | Strapped identifier of this device in the cascade |
| cmd_valid | input | 1 | Command bus qualifier |
| cmd | input | 9 | Command bus: opcode in [1:0], upper SRAM address in [8:6] |
| dq_in | input | 68 | Data bus as seen from the host side |
| dq_out | output | 68 | Data bus value driven by this device |
| dq_oe | output | 1 | Data bus output enable |
| ack_out | output | 1 | Acknowledge value |
| ack_oe | output | 1 | Acknowledge output enable |
| sram_addr | output | 22 | External SRAM address |
| sram_addr_oe | output | 1 | SRAM address output enable |
| ce_n | output | 1 | SRAM chip enable, active low |
| we_n | output | 1 | SRAM write enable, active low |
| ale_n | output | 1 | SRAM address latch enable, active low |
| ctl_oe | output | 1 | Output enable of the three SRAM strobes |
| drive_en | output | 4 | Packed enables {ctl_oe, sram_addr_oe, ack_oe, dq_oe} |

## Verification
The hardest situation to reach is a well-formed read landing while this device is already in its schedule, particularly in cycles 6 and 7 when the sequencer is about to return to idle and a slip of one cycle would let it start a second transaction. The stimulus injects complete phase A/phase B pairs into cycles 3–4 and into cycles 6–7 of a running read, then checks that the per-cycle drive pattern is unchanged and that the device is idle afterwards. It also places a new read immediately after cycle 7 to show that the boundary is exact.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN1,
    ST_TURN2,
    ST_DRIVE,
    ST_ACKLO,
    ST_STROBE,
    ST_TAIL
  } seq_state_e;

  typedef struct packed {
    logic ctl;
    logic addr;
    logic ack;
    logic dq;
  } drive_t;

  localparam int SPACE_LO  = 19;
  localparam int SPACE_HI  = 20;
  localparam logic [1:0] SPACE_SRAM = 2'b10;
  localparam int ID_LO     = 21;
  localparam int UPPER_LO  = 6;
  localparam int UPPER_W   = 3;

endpackage

// File: rtl/srd_cmd_decode.sv
module srd_cmd_decode
  import srd_pkg::*;
#(
  parameter int ID_W    = 5,
  parameter int CMD_W   = 9,
  parameter int DQ_W    = 68,
  parameter int ADDR_W  = 22,
  parameter logic [1:0] READ_OP = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              start,
  output logic [ADDR_W-1:0] addr
);

  localparam int LOW_W = ADDR_W - UPPER_W;
  localparam int ID_HI = ID_LO + ID_W - 1;

  logic is_read;
  logic phase_a_hit;
  logic pend_q;

  assign is_read     = cmd_valid && (cmd[1:0] == READ_OP)
                       && (dq_in[SPACE_HI:SPACE_LO] == SPACE_SRAM);
  assign phase_a_hit = is_read && (dq_in[ID_HI:ID_LO] == dev_id);
  assign start       = idle && pend_q && is_read;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      addr   <= '0;
    end else if (!idle || start) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= phase_a_hit;
      if (phase_a_hit)
        addr <= {cmd[UPPER_LO+UPPER_W-1:UPPER_LO], dq_in[LOW_W-1:0]};
    end
  end

  // R2 R3: a pending phase A only exists after an accepted phase-A cycle while idle
  assert_pend_origin_R2: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> $past(phase_a_hit) && $past(idle));

endmodule

// File: rtl/srd_seq_fsm.sv
module srd_seq_fsm
  import srd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       idle,
  output drive_t     drv_nxt,
  output logic       ack_nxt
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_TURN1;
      ST_TURN1:  state_d = ST_TURN2;
      ST_TURN2:  state_d = ST_DRIVE;
      ST_DRIVE:  state_d = ST_ACKLO;
      ST_ACKLO:  state_d = ST_STROBE;
      ST_STROBE: state_d = ST_TAIL;
      ST_TAIL:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    drv_nxt = '0;
    ack_nxt = 1'b0;
    unique case (state_d)
      ST_DRIVE:  drv_nxt.dq = 1'b1;
      ST_ACKLO: begin
        drv_nxt.dq  = 1'b1;
        drv_nxt.ack = 1'b1;
      end
      ST_STROBE: begin
        drv_nxt = '1;
        ack_nxt = 1'b1;
      end
      ST_TAIL:   drv_nxt.ack = 1'b1;
      default:   drv_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign idle = (state_q == ST_IDLE);

  // R5: the turnaround pair is always walked in full
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TURN1) |=> (state_q == ST_TURN2));

  // R10: the last cycle always returns to idle
  assert_tail_release_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TAIL) |=> (state_q == ST_IDLE));

  // R11: a transaction only begins from idle
  assert_entry_from_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TURN1) |-> ($past(state_q) == ST_IDLE));

endmodule

// File: rtl/srd_out_stage.sv
module srd_out_stage
  import srd_pkg::*;
#(
  parameter int DQ_W   = 68,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  drive_t            drv_nxt,
  input  logic              ack_nxt,
  input  logic [ADDR_W-1:0] addr,
  output drive_t            drv_q,
  output logic              ack_out,
  output logic              ce_n,
  output logic              we_n,
  output logic              ale_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DQ_W-1:0]   dq_out
);

  localparam int PAD_W = DQ_W - ADDR_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q     <= '0;
      ack_out   <= 1'b0;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      ale_n     <= 1'b1;
      sram_addr <= '0;
      dq_out    <= '0;
    end else begin
      drv_q     <= drv_nxt;
      ack_out   <= drv_nxt.ack && ack_nxt;
      ce_n      <= !drv_nxt.ctl;
      ale_n     <= !drv_nxt.ctl;
      we_n      <= 1'b1;
      sram_addr <= drv_nxt.addr ? addr : '0;
      dq_out    <= drv_nxt.dq ? {{PAD_W{1'b0}}, addr} : '0;
    end
  end

  // R8: strobe cycle carries the full drive pattern
  assert_strobe_pattern_R8: assert property (@(posedge clk) disable iff (rst)
    drv_q.ctl |-> (drv_q.addr && drv_q.dq && drv_q.ack && ack_out
                   && !ce_n && !ale_n && we_n));

  // R8: acknowledge high only in the strobe cycle
  assert_ack_high_R8: assert property (@(posedge clk) disable iff (rst)
    ack_out |-> drv_q.ctl);

  // R9: the cycle after the strobes keeps only acknowledge, driven low
  assert_tail_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_q.ctl) |-> (drv_q.ack && !ack_out && !drv_q.dq && !drv_q.addr));

  // R7: acknowledge leaves high impedance low, while data is already driven
  assert_ack_lead_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q.ack) |-> (drv_q.dq && !ack_out && !drv_q.ctl));

  // R6: data bus enable is a three-cycle run
  assert_dq_run_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q.dq) |=> drv_q.dq);

  // R12: first cycle after reset is quiet
  assert_reset_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (drv_q == '0));

endmodule

// File: rtl/srd_read_seq.sv
module srd_read_seq
  import srd_pkg::*;
#(
  parameter int ID_W    = 5,
  parameter int CMD_W   = 9,
  parameter int DQ_W    = 68,
  parameter int ADDR_W  = 22,
  parameter logic [1:0] READ_OP = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              ack_out,
  output logic              ack_oe,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_addr_oe,
  output logic              ce_n,
  output logic              we_n,
  output logic              ale_n,
  output logic              ctl_oe,
  output logic [3:0]        drive_en
);

  logic              idle;
  logic              start;
  logic [ADDR_W-1:0] addr;
  drive_t            drv_nxt;
  drive_t            drv_q;
  logic              ack_nxt;

  srd_cmd_decode #(
    .ID_W(ID_W), .CMD_W(CMD_W), .DQ_W(DQ_W), .ADDR_W(ADDR_W), .READ_OP(READ_OP)
  ) u_dec (
    .clk(clk), .rst(rst), .idle(idle), .dev_id(dev_id),
    .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in),
    .start(start), .addr(addr)
  );

  srd_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .idle(idle),
    .drv_nxt(drv_nxt), .ack_nxt(ack_nxt)
  );

  srd_out_stage #(.DQ_W(DQ_W), .ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .drv_nxt(drv_nxt), .ack_nxt(ack_nxt), .addr(addr),
    .drv_q(drv_q), .ack_out(ack_out), .ce_n(ce_n), .we_n(we_n), .ale_n(ale_n),
    .sram_addr(sram_addr), .dq_out(dq_out)
  );

  assign dq_oe        = drv_q.dq;
  assign ack_oe       = drv_q.ack;
  assign sram_addr_oe = drv_q.addr;
  assign ctl_oe       = drv_q.ctl;
  assign drive_en     = drv_q;  // R13: {ctl, addr, ack, dq}

  // R1: an accepted phase B is followed by the first turnaround cycle, nothing driven
  assert_start_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> (drive_en == 4'b0000) && !idle);

endmodule

// File: tb/tb_srd_read_seq.sv
module tb_srd_read_seq;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 38;
  localparam int NV = 10;

  // fields: va oa id sa hi lo vb ob sb acc
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 2'b00, 5'd9,  2'b10, 3'b101, 19'h2A5A5, 1'b1, 2'b00, 2'b10, 1'b1}, // R1 R4 good
    {1'b1, 2'b00, 5'd8,  2'b10, 3'b101, 19'h2A5A5, 1'b1, 2'b00, 2'b10, 1'b0}, // R2 wrong id
    {1'b1, 2'b00, 5'd9,  2'b01, 3'b001, 19'h00123, 1'b1, 2'b00, 2'b10, 1'b0}, // R3 space A
    {1'b1, 2'b00, 5'd9,  2'b10, 3'b001, 19'h00123, 1'b1, 2'b00, 2'b11, 1'b0}, // R3 space B
    {1'b1, 2'b01, 5'd9,  2'b10, 3'b010, 19'h00456, 1'b1, 2'b00, 2'b10, 1'b0}, // R3 opcode A
    {1'b1, 2'b00, 5'd9,  2'b10, 3'b010, 19'h00456, 1'b0, 2'b00, 2'b10, 1'b0}, // R3 valid B
    {1'b1, 2'b00, 5'd9,  2'b10, 3'b111, 19'h7FFFF, 1'b1, 2'b00, 2'b10, 1'b1}, // R4 all ones
    {1'b1, 2'b00, 5'd9,  2'b10, 3'b000, 19'h00000, 1'b1, 2'b00, 2'b10, 1'b1}, // R4 zero
    {1'b1, 2'b00, 5'd9,  2'b10, 3'b011, 19'h11111, 1'b1, 2'b10, 2'b10, 1'b0}, // R3 opcode B
    {1'b0, 2'b00, 5'd9,  2'b10, 3'b011, 19'h11111, 1'b1, 2'b00, 2'b10, 1'b0}  // R3 valid A
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dev_id = 5'd9;
  logic        cmd_valid = 1'b0;
  logic [8:0]  cmd = '0;
  logic [67:0] dq_in = '0;
  logic [67:0] dq_out;
  logic        dq_oe, ack_out, ack_oe, sram_addr_oe, ce_n, we_n, ale_n, ctl_oe;
  logic [21:0] sram_addr;
  logic [3:0]  drive_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  srd_read_seq dut (
    .clk(clk), .rst(rst), .dev_id(dev_id), .cmd_valid(cmd_valid), .cmd(cmd),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ack_out(ack_out),
    .ack_oe(ack_oe), .sram_addr(sram_addr), .sram_addr_oe(sram_addr_oe),
    .ce_n(ce_n), .we_n(we_n), .ale_n(ale_n), .ctl_oe(ctl_oe), .drive_en(drive_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic put(input logic v, input logic [1:0] op, input logic [4:0] id,
                     input logic [1:0] sp, input logic [2:0] hi, input logic [18:0] lo);
    cmd_valid     = v;
    cmd           = {hi, 4'b0000, op};
    dq_in         = '0;
    dq_in[25:21]  = id;
    dq_in[20:19]  = sp;
    dq_in[18:0]   = lo;
  endtask

  task automatic put_idle();
    put(1'b0, 2'b11, 5'd0, 2'b00, 3'b000, 19'h0);
  endtask

  // c: transaction cycle (2..7), anything else means idle
  task automatic chk(input int c, input logic acc, input logic [21:0] a, input string tag);
    logic [3:0]  en;
    logic        ak, ce, we, al;
    logic [21:0] sa, dq;
    logic [52:0] exp_v, got_v;
    en = 4'b0000; ak = 0; ce = 1; we = 1; al = 1; sa = '0; dq = '0;
    if (acc) begin
      case (c)
        4: begin en = 4'b0001; dq = a; end
        5: begin en = 4'b0011; dq = a; end
        6: begin en = 4'b1111; dq = a; ak = 1; ce = 0; al = 0; sa = a; end
        7: en = 4'b0010;
        default: en = 4'b0000;
      endcase
    end
    exp_v = {en, ak, ce, we, al, sa, dq, 1'b0};
    got_v = {drive_en, ack_out, ce_n, we_n, ale_n, sram_addr, dq_out[21:0], |dq_out[67:22]};
    n_chk++;
    if (got_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, c, got_v, exp_v);
    end
  endtask

  function automatic string tag_of(input int c, input logic acc);
    if (!acc) return "R2 R3";
    case (c)
      2, 3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8 R4";
      7: return "R9";
      default: return "R10";
    endcase
  endfunction

  // inj: 0 none, 1 good pair in cycles 3-4, 2 good pair in cycles 6-7 (R11)
  task automatic run_txn(input logic [VW-1:0] v, input int inj);
    logic [21:0] a;
    a = {v[27:25], v[24:6]};
    @(negedge clk);
    chk(8, 1'b0, '0, "R10");
    put(v[37], v[36:35], v[34:30], v[29:28], v[27:25], v[24:6]);
    @(negedge clk);
    put(v[5], v[4:3], 5'd0, v[2:1], 3'b000, ~v[24:6]);
    for (int c = 2; c <= 7; c++) begin
      @(negedge clk);
      chk(c, v[0], a, inj != 0 ? "R11" : tag_of(c, v[0]));
      if ((inj == 1 && c == 3) || (inj == 2 && c == 6))
        put(1'b1, 2'b00, 5'd9, 2'b10, 3'b110, 19'h0F0F0);
      else if ((inj == 1 && c == 4) || (inj == 2 && c == 7))
        put(1'b1, 2'b00, 5'd0, 2'b10, 3'b000, 19'h0);
      else
        put_idle();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    put_idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 R13: reset state
    chk(0, 1'b0, '0, "R12 R13");

    for (int i = 0; i < NV; i++) run_txn(VEC[i], 0);

    // R10: back-to-back reads, next phase A right after cycle 7
    run_txn(VEC[0], 0);
    run_txn(VEC[6], 0);

    // R11: good pairs injected during a running read
    run_txn(VEC[7], 1);
    run_txn(VEC[0], 2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(8, 1'b0, '0, "R11");
    end

    // R12: reset in mid-transaction
    @(negedge clk);
    put(1'b1, 2'b00, 5'd9, 2'b10, 3'b101, 19'h2A5A5);
    @(negedge clk);
    put(1'b1, 2'b00, 5'd0, 2'b10, 3'b000, 19'h0);
    for (int c = 2; c <= 5; c++) begin
      @(negedge clk);
      put_idle();
      chk(c, 1'b1, {3'b101, 19'h2A5A5}, "R12");
    end
    rst = 1'b1;
    @(negedge clk);
    chk(0, 1'b0, '0, "R12");
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(0, 1'b0, '0, "R12");
    end

    // R1: works again after the mid-read reset
    run_txn(VEC[6], 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule